// File: doc/BRIEF.md
# Radar Test Pulse Train Generator

The block produces two periodic pulse trains for exercising a radar receiver under test, both timed from a single 10 MHz clock (100 ns per clock). The fast train repeats every 60 clocks (6 µs) and stays high for 12 clocks (1.2 µs). The slow train repeats every 600 clocks (60 µs) and stays high for 30 clocks (3 µs).

Both trains are built the same way. A modulo counter emits a strobe that is one clock wide. That strobe sets a pulse flag. A width counter then clears the flag after a fixed number of clocks. The width counter is held at zero while the flag is low, so it runs only during a pulse.

The slow train does not take the clock directly. Its modulo counter advances once for each rising edge of the fast flag, and a registered edge detector finds those edges, so the slow train is cascaded off the fast one. A plain hold input lets a downstream gating stage force the slow train low and restart its count. All pins are plain level signals. No data stream crosses the block boundary, so it has no valid/ready handshake and no back-pressure.

Top module: `prf_pulse_gen`

## Requirements
- R1: After a synchronous reset is released, `hi_pulse` first goes high after 60 clock edges. It then repeats with a period of exactly 60 clocks.
- R2: Each `hi_pulse` high time is exactly 12 clocks.
- R3: Each modulo counter emits a strobe one clock wide when its count reaches modulus minus one while enabled. In that same cycle it wraps to zero.
- R4: A strobe sets its pulse flag on the next clock edge. If the width counter finishes on the same edge, the clear wins and the flag goes low.
- R5: A width counter stays at zero whenever its flag is low, and counts only while its flag is high.
- R6: `med_pulse` goes high on the clock edge after the 10th counted rising edge of `hi_pulse`. With no hold it repeats every 600 clocks, and its first rise comes 601 clock edges after reset is released.
- R7: Each `med_pulse` high time is exactly 30 clocks.
- R8: While `med_hold` is high, `med_pulse` is low from the next edge on. The rising-edge count and the slow width counter return to zero, and `hi_pulse` rising edges seen during hold are not counted. After release, ten new rising edges are needed before the next `med_pulse`.
- R9: `med_hold` has no effect on `hi_pulse`.
- R10: While `rst` is high, both outputs are low on each clock edge, and all counting restarts when it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz timing clock |
| rst | input | 1 | Synchronous reset, active high |
| med_hold | input | 1 | Active high: forces the slow train low and clears its count |
| hi_pulse | output | 1 | Fast train, 60-clock period, 12-clock high time |
| med_pulse | output | 1 | Slow train, 600-clock period, 30-clock high time |

## Verification
The hardest situations to reach are a hold that arrives while a slow pulse is already high, and a hold that spans `hi_pulse` rising edges. The first must cut the pulse short. The second must keep those edges out of the count, so the next slow pulse slips by the held edges. The stimulus runs past two full slow periods, raises `med_hold` in the middle of the second slow pulse, and later holds it across several fast edges. A reset is also applied in the middle of the run. A cycle-level reference model in the bench predicts both outputs for every clock, so each shift in timing is checked exactly.

// File: rtl/prf_pkg.sv
package prf_pkg;

  // Counter width able to hold the values 0 .. n-1, never narrower than one bit.
  function automatic int cnt_bits(input int n);
    int b;
    b = $clog2(n);
    if (b < 1) b = 1;
    return b;
  endfunction

  // Behaviour of a pulse flag when a set strobe and a width expiry coincide.
  typedef enum logic [0:0] {
    PRIO_CLEAR = 1'b0,
    PRIO_SET   = 1'b1
  } flag_prio_e;

endpackage

// File: rtl/prf_mod_counter.sv
module prf_mod_counter #(
  parameter int MOD = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic stb
);
  localparam int W = prf_pkg::cnt_bits(MOD);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last = (cnt_q == LAST);
  assign stb     = en && at_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      if (at_last) cnt_q <= '0;
      else         cnt_q <= cnt_q + W'(1);
    end
  end

  // R3: the strobe wraps the count back to zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (stb && !clr) |=> (cnt_q == '0));

  // R3: the count never leaves its modulus range
  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  generate
    if (MOD > 1) begin : g_single
      // R3: a strobe lasts one clock only
      a_r3_single_clock: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);
    end
  endgenerate

endmodule

// File: rtl/prf_width_flag.sv
module prf_width_flag #(
  parameter int                  WIDTH = 12,
  parameter prf_pkg::flag_prio_e PRIO  = prf_pkg::PRIO_CLEAR
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set_stb,
  output logic flag
);
  localparam int W = prf_pkg::cnt_bits(WIDTH);
  localparam logic [W-1:0] LAST = W'(WIDTH - 1);

  logic         flag_q;
  logic [W-1:0] wcnt_q;
  logic         expire;
  logic         flag_d;

  assign expire = flag_q && (wcnt_q == LAST);

  generate
    if (PRIO == prf_pkg::PRIO_CLEAR) begin : g_clear_wins
      always_comb begin
        if (expire)       flag_d = 1'b0;
        else if (set_stb) flag_d = 1'b1;
        else              flag_d = flag_q;
      end
    end else begin : g_set_wins
      always_comb begin
        if (set_stb)     flag_d = 1'b1;
        else if (expire) flag_d = 1'b0;
        else             flag_d = flag_q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) flag_q <= 1'b0;
    else            flag_q <= flag_d;
  end

  // Width counter is held at zero whenever the flag is low.
  always_ff @(posedge clk) begin
    if (rst || clr || !flag_q || expire) wcnt_q <= '0;
    else                                 wcnt_q <= wcnt_q + W'(1);
  end

  assign flag = flag_q;

  // R4: a strobe with no expiry raises the flag
  a_r4_set_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (set_stb && !clr && !expire) |=> flag_q);

  // R4: expiry with clear priority drops the flag even with a strobe
  a_r4_clear_priority: assert property (@(posedge clk) disable iff (rst)
    (expire && PRIO == prf_pkg::PRIO_CLEAR) |=> !flag_q);

  // R5: width counter idles at zero while the flag is low
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !flag_q |-> (wcnt_q == '0));

  // R5: width counter advances by one per clock while the pulse runs
  a_r5_counts_high: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !expire && !clr) |=> (wcnt_q == $past(wcnt_q) + W'(1)));

  // R2: the counter never passes the programmed width
  a_r2_width_bound: assert property (@(posedge clk) disable iff (rst)
    wcnt_q <= LAST);

endmodule

// File: rtl/prf_rise_det.sv
module prf_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig;
  end

  assign rise = sig && !sig_q;

  // R6: a detected rise cannot repeat on the following clock
  a_r6_rise_isolated: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/prf_pulse_gen.sv
module prf_pulse_gen #(
  parameter int HI_MOD    = 60,
  parameter int HI_WIDTH  = 12,
  parameter int MED_DIV   = 10,
  parameter int MED_WIDTH = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic med_hold,
  output logic hi_pulse,
  output logic med_pulse
);
  logic hi_stb;
  logic hi_flag;
  logic hi_rise;
  logic med_stb;
  logic med_flag;

  // Fast train: free-running divider and width flag.
  prf_mod_counter #(.MOD(HI_MOD)) hi_div_i (
    .clk (clk),
    .rst (rst),
    .clr (1'b0),
    .en  (1'b1),
    .stb (hi_stb)
  );

  prf_width_flag #(.WIDTH(HI_WIDTH), .PRIO(prf_pkg::PRIO_CLEAR)) hi_flag_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (1'b0),
    .set_stb (hi_stb),
    .flag    (hi_flag)
  );

  // Slow train: counts rising edges of the fast flag.
  prf_rise_det hi_edge_i (
    .clk  (clk),
    .rst  (rst),
    .sig  (hi_flag),
    .rise (hi_rise)
  );

  prf_mod_counter #(.MOD(MED_DIV)) med_div_i (
    .clk (clk),
    .rst (rst),
    .clr (med_hold),
    .en  (hi_rise),
    .stb (med_stb)
  );

  prf_width_flag #(.WIDTH(MED_WIDTH), .PRIO(prf_pkg::PRIO_CLEAR)) med_flag_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (med_hold),
    .set_stb (med_stb),
    .flag    (med_flag)
  );

  assign hi_pulse  = hi_flag;
  assign med_pulse = med_flag;

  // R8: hold forces the slow train low on the next edge
  a_r8_hold_low: assert property (@(posedge clk) disable iff (rst)
    med_hold |=> !med_pulse);

  // R6: the slow divider strobes only on a fast rising edge
  a_r6_stb_on_rise: assert property (@(posedge clk) disable iff (rst)
    med_stb |-> hi_rise);

  // R6: a slow pulse starts only after a counted fast edge
  a_r6_start_after_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(med_pulse) |-> $past(hi_rise));

  // R1: fast rising edges line up with the fast divider strobe
  a_r1_rise_after_stb: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_pulse) |-> $past(hi_stb));

  // R10: outputs are low immediately after a reset edge
  a_r10_reset_low: assert property (@(posedge clk)
    $past(rst) |-> (!hi_pulse && !med_pulse));

endmodule

// File: tb/prf_pulse_gen_tb_top.sv
module prf_pulse_gen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic med_hold = 1'b0;
  logic hi_pulse;
  logic med_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // 200 MHz: 5 time units per cycle
  always begin
    #2 clk = 1'b1;
    #3 clk = 1'b0;
  end

  prf_pulse_gen dut_i (
    .clk       (clk),
    .rst       (rst),
    .med_hold  (med_hold),
    .hi_pulse  (hi_pulse),
    .med_pulse (med_pulse)
  );

  // Reference model state, written from the requirements
  int n = 0;
  bit m_flag = 1'b0;
  int m_cnt = 0;
  int m_w = 0;
  logic [1:0] exp_q[$];
  int step_no = 0;

  function automatic bit hi_at(input int k);
    return (k >= 60) && (((k - 60) % 60) < 12);   // R1 R2
  endfunction

  // Driver: apply inputs at the falling edge and push the expected outputs
  // for the state after the next rising edge.
  task automatic step(input bit r, input bit h);
    bit rise;
    bit done;
    bit stb;
    rst = r;
    med_hold = h;
    if (r) begin                                  // R10
      n = 0; m_flag = 1'b0; m_cnt = 0; m_w = 0;
    end else begin
      rise = hi_at(n) && (n == 0 ? 1'b1 : !hi_at(n - 1));
      if (h) begin                                // R8
        m_flag = 1'b0; m_cnt = 0; m_w = 0;
      end else begin
        done = m_flag && (m_w == 29);             // R7
        stb  = rise && (m_cnt == 9);              // R6
        if (rise) m_cnt = (m_cnt == 9) ? 0 : m_cnt + 1;
        if (m_flag) m_w = done ? 0 : m_w + 1;
        else        m_w = 0;
        if (done)     m_flag = 1'b0;
        else if (stb) m_flag = 1'b1;
      end
      n++;
    end
    exp_q.push_back({hi_at(n), m_flag});
    @(negedge clk);
  endtask

  // Monitor: pop one expectation per cycle, sampled after the rising edge
  initial begin
    forever begin
      logic [1:0] e;
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        step_no++;
        checks++;
        if (hi_pulse !== e[1]) begin
          errors++;
          $display("FAIL R1 R2 R3 R4 R5 R9 R10 hi_pulse cycle %0d actual %b expected %b",
                   step_no, hi_pulse, e[1]);
        end
        checks++;
        if (med_pulse !== e[0]) begin
          errors++;
          $display("FAIL R6 R7 R8 R10 med_pulse cycle %0d actual %b expected %b",
                   step_no, med_pulse, e[0]);
        end
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);       // R10 reset state
    for (int i = 0; i < 1205; i++) step(1'b0, 1'b0);    // R1 R2 R6 R7 two slow pulses
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);       // R8 hold inside a slow pulse
    for (int i = 0; i < 1300; i++) step(1'b0, 1'b0);    // R8 count restarts
    for (int i = 0; i < 200; i++) step(1'b0, 1'b1);     // R8 R9 hold across fast edges
    for (int i = 0; i < 700; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0);       // R10 reset mid-run
    for (int i = 0; i < 700; i++) step(1'b0, 1'b0);     // R10 restart timing
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule